// File: doc/BRIEF.md
# Shared I/O Port Bank with Multiplexed Memory Bus

This block provides four 8-bit general-purpose ports, 32 lines in all. Each port has an output latch that software writes and a pin level that software reads back. A line becomes an input when its latch bit holds 1. In that state the block stops pulling the line low, so an outside source sets the level. Port 0 is open-drain and has no pull-up. Ports 1 to 3 have weak pull-ups. Each line is modelled as a drive enable plus a drive value, and a constant per-line pull-up flag is provided, so a testbench can resolve the pad level itself.

An external memory cycle takes over two of the ports. Port 0 first presents the low address byte, with an address strobe high. It then carries the data byte: driven for a write, released for a read. Port 2 presents the high address byte, but only when the cycle uses a 16-bit address. For an 8-bit-address cycle, port 2 stays under the control of its latch. When the cycle ends, both ports return to their latches.

Top module: `mcu_port_mux`

## Requirements
- R1: After reset every latch holds 0xFF, so no line is driven (pin_oe all 0) and the address strobe and bus-busy flag are low.
- R2: With wr_en high, wr_data is stored at the clock edge into the latch of port wr_sel (0..3). Outside a bus cycle, a latch bit of 0 drives its line low (pin_oe=1, pin_out=0), and a latch bit of 1 leaves the line undriven. Wherever pin_oe is 0, pin_out is 0.
- R3: pin_pu is 0 for every port-0 line and 1 for every line of ports 1 to 3. When not owned by the bus, port 0 never drives a line high.
- R4: rd_data equals the pin_in byte of port rd_sel (bits rd_sel*8 upward). A line whose latch bit is 1 reads 0 when an outside source pulls it low.
- R5: A bus_req sampled high while idle starts a cycle at that edge. For the next single clock, bus_ale is high and port 0 drives bus_addr[7:0] on all eight lines.
- R6: When bus_wide is high, port 2 drives bus_addr[15:8] on all eight lines for the whole cycle, in both the address phase and the data phase.
- R7: When bus_wide is low, port 2 keeps its latch-driven behaviour throughout the cycle.
- R8: In a write cycle (bus_wr=1), port 0 drives bus_wdata on all lines for DATA_CYCLES clocks after the address phase.
- R9: In a read cycle, port 0 is undriven during the data phase. At the last data-phase edge, bus_rdata captures the port-0 pin_in byte and then holds it.
- R10: bus_busy is high from the address phase through the last data clock. On the following clock both ports return to their latches. bus_req is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 2 | Port selected for the latch write |
| wr_data | input | 8 | Latch write value |
| rd_sel | input | 2 | Port selected for pin read |
| rd_data | output | 8 | Pin levels of the selected port |
| pin_in | input | 32 | Resolved pad levels, port p on bits 8p+7..8p |
| pin_oe | output | 32 | Per-line active drive enable |
| pin_out | output | 32 | Per-line drive value |
| pin_pu | output | 32 | Per-line weak pull-up present |
| bus_req | input | 1 | Request an external memory cycle |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| bus_addr | input | 16 | Cycle address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Captured read data |
| bus_ale | output | 1 | Address strobe, high during the address phase |
| bus_busy | output | 1 | External cycle in progress |

## Verification
The assertions assume that pin_in is the resolved pad level. That means it follows pin_out on every line where pin_oe is high, and the read-capture check relies on this. The bench builds pin_in from the design's own drive outputs, the outside drivers and the pull-up flags, with active drive taking priority. An outside driver on port 0 can therefore never override an address or write-data byte. Requests are also held across busy periods, so the assertions see back-to-back cycles as well as single ones.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bus_st_e;
endpackage

// File: rtl/mpm_latch_bank.sv
module mpm_latch_bank #(
    parameter int NP = 4,
    parameter int PW = 8,
    localparam int SW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_sel,
    input  logic [PW-1:0]    wr_data,
    output logic [NP*PW-1:0] latch
);
    typedef struct packed {
        logic [NP*PW-1:0] lat;
    } lat_regs_t;

    lat_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.lat[int'(wr_sel)*PW +: PW] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{lat: '1};
        else        r_q <= r_d;
    end

    assign latch = r_q.lat;

    // R2: an unselected port keeps its value across a write
    a_r2_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != '0) |=> latch[PW-1:0] == $past(latch[PW-1:0]));
endmodule

// File: rtl/mpm_bus_fsm.sv
module mpm_bus_fsm #(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int DATA_CYCLES = 2,
    localparam int CW = (DATA_CYCLES > 1) ? $clog2(DATA_CYCLES) : 1,
    localparam int HW = AW - DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic          wide,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] p0_pin,
    output logic          ale,
    output logic          busy,
    output logic          lo_own,
    output logic          lo_oe,
    output logic [DW-1:0] lo_val,
    output logic          hi_own,
    output logic [HW-1:0] hi_val,
    output logic          rd_ph,
    output logic [DW-1:0] rdata
);
    import mpm_pkg::*;

    localparam logic [CW-1:0] LAST = CW'(DATA_CYCLES - 1);

    typedef struct packed {
        bus_st_e       st;
        logic [AW-1:0] addr;
        logic          wr;
        logic          wide;
        logic [DW-1:0] wdata;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rdata;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.st    = ST_ADDR;
                    r_d.addr  = addr;
                    r_d.wr    = wr;
                    r_d.wide  = wide;
                    r_d.wdata = wdata;
                end
            end
            ST_ADDR: begin
                r_d.st  = ST_DATA;
                r_d.cnt = '0;
            end
            ST_DATA: begin
                if (r_q.cnt == LAST) begin
                    r_d.st = ST_IDLE;
                    if (!r_q.wr) r_d.rdata = p0_pin;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ale    = (r_q.st == ST_ADDR);
    assign busy   = (r_q.st != ST_IDLE);
    assign lo_own = busy;
    assign lo_oe  = ale || (r_q.st == ST_DATA && r_q.wr);
    assign lo_val = ale ? r_q.addr[DW-1:0] : r_q.wdata;
    assign hi_own = busy && r_q.wide;
    assign hi_val = r_q.addr[AW-1:DW];
    assign rd_ph  = (r_q.st == ST_DATA) && !r_q.wr;
    assign rdata  = r_q.rdata;

    // R5: the strobe lasts exactly one clock
    a_r5_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R5: every cycle opens with the address phase
    a_r5_busy_starts_ale: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ale);

    // R10: the strobe follows an idle clock, so requests while busy are dropped
    a_r10_ale_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(r_q.st) == ST_IDLE);

    // R9: captured data is stable outside the capture edge
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ph |=> $stable(rdata));
endmodule

// File: rtl/mpm_pin_drive.sv
module mpm_pin_drive #(
    parameter int PW         = 8,
    parameter bit OPEN_DRAIN = 1'b0
) (
    input  logic [PW-1:0] latch,
    input  logic          bus_own,
    input  logic          bus_oe,
    input  logic [PW-1:0] bus_val,
    output logic [PW-1:0] oe,
    output logic [PW-1:0] out,
    output logic [PW-1:0] pu
);
    always_comb begin
        if (bus_own) begin
            oe  = {PW{bus_oe}};
            out = bus_val & {PW{bus_oe}};
        end else begin
            oe  = ~latch;
            out = '0;
        end
    end

    generate
        if (OPEN_DRAIN) begin : g_od
            assign pu = '0;
        end else begin : g_pu
            assign pu = '1;
        end
    endgenerate
endmodule

// File: rtl/mcu_port_mux.sv
module mcu_port_mux #(
    parameter int NP          = 4,
    parameter int PW          = 8,
    parameter int AW          = 16,
    parameter int DATA_CYCLES = 2,
    localparam int SW = (NP > 1) ? $clog2(NP) : 1,
    localparam int TW = NP * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [PW-1:0] wr_data,
    input  logic [SW-1:0] rd_sel,
    output logic [PW-1:0] rd_data,
    input  logic [TW-1:0] pin_in,
    output logic [TW-1:0] pin_oe,
    output logic [TW-1:0] pin_out,
    output logic [TW-1:0] pin_pu,
    input  logic          bus_req,
    input  logic          bus_wr,
    input  logic          bus_wide,
    input  logic [AW-1:0] bus_addr,
    input  logic [PW-1:0] bus_wdata,
    output logic [PW-1:0] bus_rdata,
    output logic          bus_ale,
    output logic          bus_busy
);
    localparam int LO_PORT = 0;
    localparam int HI_PORT = 2;

    logic [TW-1:0]    latch;
    logic             lo_own, lo_oe, hi_own, rd_ph;
    logic [PW-1:0]    lo_val;
    logic [AW-PW-1:0] hi_val;

    mpm_latch_bank #(.NP(NP), .PW(PW)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .latch(latch)
    );

    mpm_bus_fsm #(.AW(AW), .DW(PW), .DATA_CYCLES(DATA_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .wr(bus_wr), .wide(bus_wide),
        .addr(bus_addr), .wdata(bus_wdata), .p0_pin(pin_in[LO_PORT*PW +: PW]),
        .ale(bus_ale), .busy(bus_busy), .lo_own(lo_own), .lo_oe(lo_oe),
        .lo_val(lo_val), .hi_own(hi_own), .hi_val(hi_val), .rd_ph(rd_ph),
        .rdata(bus_rdata)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        logic          own, boe;
        logic [PW-1:0] bval;
        if (p == LO_PORT) begin : g_lo
            assign own  = lo_own;
            assign boe  = lo_oe;
            assign bval = lo_val;
        end else if (p == HI_PORT) begin : g_hi
            assign own  = hi_own;
            assign boe  = 1'b1;
            assign bval = PW'(hi_val);
        end else begin : g_gp
            assign own  = 1'b0;
            assign boe  = 1'b0;
            assign bval = '0;
        end
        mpm_pin_drive #(.PW(PW), .OPEN_DRAIN(p == LO_PORT)) u_drv (
            .latch(latch[p*PW +: PW]), .bus_own(own), .bus_oe(boe),
            .bus_val(bval), .oe(pin_oe[p*PW +: PW]),
            .out(pin_out[p*PW +: PW]), .pu(pin_pu[p*PW +: PW])
        );
    end

    assign rd_data = pin_in[int'(rd_sel)*PW +: PW];

    // R3: port 0 as plain I/O only ever sinks
    a_r3_lo_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> (pin_oe[LO_PORT*PW +: PW] & pin_out[LO_PORT*PW +: PW]) == '0);

    // R9: the data phase of a read releases port 0
    a_r9_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ph |-> pin_oe[LO_PORT*PW +: PW] == '0);

    // R7: a narrow cycle leaves port 2 with its latch
    a_r7_narrow_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && !hi_own) |-> pin_oe[HI_PORT*PW +: PW] == ~latch[HI_PORT*PW +: PW]);

    // R6: a wide cycle drives every port-2 line
    a_r6_wide_drive: assert property (@(posedge clk) disable iff (!rst_n)
        hi_own |-> pin_oe[HI_PORT*PW +: PW] == '1);

    // R2: no drive value without a drive enable
    a_r2_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/mcu_port_mux_bench.sv
`timescale 1ns/1ps
module mcu_port_mux_bench;
    localparam int NP = 4, PW = 8, AW = 16, DC = 2, TW = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0, rd_sel = '0;
    logic [7:0]    wr_data = '0, rd_data, bus_wdata = '0, bus_rdata;
    logic [TW-1:0] pin_in, pin_oe, pin_out, pin_pu;
    logic [TW-1:0] ext_en = '0, ext_val = '0;
    logic          bus_req = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic          bus_ale, bus_busy;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // pad resolution: active drive, then outside source, then pull-up, else floats low
    always_comb
        for (int i = 0; i < TW; i++)
            pin_in[i] = pin_oe[i] ? pin_out[i] : ext_en[i] ? ext_val[i] : pin_pu[i];

    mcu_port_mux #(.NP(NP), .PW(PW), .AW(AW), .DATA_CYCLES(DC)) u_mcu_port_mux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .pin_pu(pin_pu), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ale(bus_ale), .bus_busy(bus_busy)
    );

    // reference model: phase 0 idle, 1 address, 2 data
    logic [TW-1:0] m_lat = '1;
    int            m_ph = 0, m_cnt = 0;
    logic [15:0]   m_addr = '0;
    logic [7:0]    m_wd = '0, m_rd = '0;
    logic          m_wr = 0, m_wide = 0;

    task automatic model_drive(output logic [TW-1:0] eoe, output logic [TW-1:0] eout);
        eoe = ~m_lat; eout = '0;
        if (m_ph != 0) begin
            if (m_ph == 1 || m_wr) begin
                eoe[7:0] = 8'hFF; eout[7:0] = (m_ph == 1) ? m_addr[7:0] : m_wd;
            end else begin
                eoe[7:0] = 8'h00; eout[7:0] = 8'h00;
            end
            if (m_wide) begin eoe[23:16] = 8'hFF; eout[23:16] = m_addr[15:8]; end
        end
    endtask

    function automatic logic [TW-1:0] level(logic [TW-1:0] eoe, logic [TW-1:0] eout);
        logic [TW-1:0] r;
        for (int i = 0; i < TW; i++)
            r[i] = eoe[i] ? eout[i] : ext_en[i] ? ext_val[i] : (i >= PW);
        return r;
    endfunction

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [TW-1:0] eoe, eout, lv;
        string t0, t2;
        model_drive(eoe, eout);
        lv = level(eoe, eout);
        t0 = (m_ph == 0) ? "R2" : (m_ph == 1) ? "R5" : m_wr ? "R8" : "R9";
        t2 = (m_ph == 0) ? "R2" : m_wide ? "R6" : "R7";
        cmp(t0, "p0 oe", 32'(pin_oe[7:0]), 32'(eoe[7:0]));
        cmp(t0, "p0 out", 32'(pin_out[7:0]), 32'(eout[7:0]));
        cmp("R2", "p1 oe/out", {pin_oe[15:8], pin_out[15:8]}, {eoe[15:8], eout[15:8]});
        cmp(t2, "p2 oe", 32'(pin_oe[23:16]), 32'(eoe[23:16]));
        cmp(t2, "p2 out", 32'(pin_out[23:16]), 32'(eout[23:16]));
        cmp("R2", "p3 oe/out", {pin_oe[31:24], pin_out[31:24]}, {eoe[31:24], eout[31:24]});
        cmp("R3", "pull-ups", pin_pu, 32'hFFFF_FF00);
        cmp("R4", "rd_data", 32'(rd_data), 32'(lv[int'(rd_sel)*8 +: 8]));
        cmp("R5", "ale", 32'(bus_ale), 32'(m_ph == 1));
        cmp("R10", "busy", 32'(bus_busy), 32'(m_ph != 0));
        cmp("R9", "rdata", 32'(bus_rdata), 32'(m_rd));
    endtask

    task automatic tick();
        logic [TW-1:0] eoe, eout, lv;
        model_drive(eoe, eout);
        lv = level(eoe, eout);
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_lat = '1; m_ph = 0; m_cnt = 0; m_addr = '0; m_wd = '0; m_rd = '0;
            m_wr = 0; m_wide = 0;
        end else begin
            if (wr_en) m_lat[int'(wr_sel)*8 +: 8] = wr_data;
            case (m_ph)
                0: if (bus_req) begin
                       m_ph = 1; m_addr = bus_addr; m_wr = bus_wr;
                       m_wide = bus_wide; m_wd = bus_wdata;
                   end
                1: begin m_ph = 2; m_cnt = 0; end
                default: if (m_cnt == DC - 1) begin
                             m_ph = 0;
                             if (!m_wr) m_rd = lv[7:0];
                         end else m_cnt++;
            endcase
            compare_all();
        end
    endtask

    task automatic wlat(int p, logic [7:0] v);
        wr_en = 1; wr_sel = 2'(p); wr_data = v;
        tick();
        wr_en = 0;
    endtask

    task automatic bus_cycle(logic w, logic wd, logic [15:0] a, logic [7:0] d);
        bus_req = 1; bus_wr = w; bus_wide = wd; bus_addr = a; bus_wdata = d;
        tick();
        bus_req = 0;
        repeat (DC + 2) tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        #1;
        // R1: reset leaves all lines released and the bus idle
        cmp("R1", "oe after reset", pin_oe, 32'h0);
        cmp("R1", "ale/busy after reset", {bus_ale, bus_busy}, 2'b00);
        tick();

        wlat(1, 8'h5A); wlat(3, 8'h0F); wlat(0, 8'h00); wlat(2, 8'h3C);
        // R4: outside source pulls port-1 lines low
        rd_sel = 1; ext_en[15:8] = 8'hFF; ext_val[15:8] = 8'h00; tick();
        ext_val[15:8] = 8'hFF; tick();
        rd_sel = 3; ext_en[31:24] = 8'hF0; ext_val[31:24] = 8'h50; tick();
        // R3: port 0 latched high floats, no high drive
        wlat(0, 8'hFF); rd_sel = 0; tick();
        ext_en[7:0] = 8'h0F; ext_val[7:0] = 8'h06; tick();
        ext_en[7:0] = 8'h00; wlat(0, 8'hC3); tick();
        wlat(0, 8'hFF);

        // R5 R6 R8: wide write
        bus_cycle(1, 1, 16'h1234, 8'hC3);
        // R7 R9: narrow read, memory returns A5 on port 0
        ext_en[7:0] = 8'hFF; ext_val[7:0] = 8'hA5; rd_sel = 0;
        bus_cycle(0, 0, 16'h0077, 8'h00);
        // R6 R9: wide read
        ext_val[7:0] = 8'h3E;
        bus_cycle(0, 1, 16'hBEEF, 8'h00);
        ext_en[7:0] = 8'h00;

        // R10: request held high gives back-to-back cycles; latch write mid-cycle
        bus_req = 1; bus_wr = 1; bus_wide = 1; bus_addr = 16'h8001; bus_wdata = 8'h99;
        tick(); tick();
        wlat(2, 8'hF0);
        bus_addr = 16'h4002;
        repeat (6) tick();
        bus_req = 0;
        repeat (5) tick();
        // R7: narrow write with port 2 latch fully low
        wlat(2, 8'h00);
        bus_cycle(1, 0, 16'hFF55, 8'h18);
        wlat(0, 8'h81); tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule